// File: doc/BRIEF.md
# DMA Channel Interrupt Status and Mask Unit

This block collects the interrupt bookkeeping for one DMA channel. A 12-bit status register latches events from the channel datapath. Software clears status bits by writing ones to them. A 12-bit mask, which software cannot write directly, decides which pending bits reach the single level interrupt output. Software changes the mask only through two write-only strobe registers: one unmasks bits and the other masks them.

Two 8-bit accounting counters count the source and destination descriptor-done events. Each counter raises its own error status bit when it wraps, and each clears when software reads it. Register accesses use a plain 32-bit word port. An access to an unmapped word offset reads as zero, changes nothing, and flags status bit 0.

All control and status pins are plain single-cycle signals. The register port has no back-pressure. A request with `reg_req` high is accepted on the clock edge where it is sampled. Read data is registered.

Top module: `dma_irq_ctrl`

## Requirements
- R1: Status bit positions, from bit 0 upward, are:
  - 0: invalid register access
  - 1: source descriptor done
  - 2: destination descriptor done
  - 3: byte count overflow
  - 4: source accounting error
  - 5: destination accounting error
  - 6: source descriptor read error
  - 7: destination descriptor read error
  - 8: data read error
  - 9: data write error
  - 10: transfer done
  - 11: pause

  A pulse on `evt_set[i]` sets status bit i.
- R2: The status register is at word offset 0. A write there clears every status bit whose data bit is one. Bits 31:12 read as zero.
- R3: When a hardware set and a software clear hit the same status bit in one cycle, the bit ends up set.
- R4: The mask register is at word offset 1 and resets to 0xFFF. Writes to it have no effect.
- R5: A write to the enable register (offset 2) clears each mask bit whose data bit is one. A write to the disable register (offset 3) sets each mask bit whose data bit is one. Both registers read as zero.
- R6: `irq` is a registered output. It is high one clock after any status bit is set while its mask bit is clear.
- R7: A pulse on `src_dscr_done` increments the source counter (offset 4) and sets status bit 1. A pulse on `dst_dscr_done` increments the destination counter (offset 5) and sets status bit 2.
- R8: An increment of a counter that holds 255 wraps it to 0. It sets status bit 4 for the source counter or bit 5 for the destination counter.
- R9: A read of a counter returns its value and clears it to zero. An increment in the same cycle as the read leaves the counter at 1.
- R10: An access to word offsets 6 and above reads as zero, changes no register, and sets status bit 0.
- R11: `reg_rdata` takes the addressed value on the clock edge that samples a read, and holds it until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_set | input | 12 | Per-bit status set pulses from the channel |
| src_dscr_done | input | 1 | Source descriptor completed with interrupt request |
| dst_dscr_done | input | 1 | Destination descriptor completed with interrupt request |
| reg_req | input | 1 | Register access request |
| reg_we | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 4 | Word offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| irq | output | 1 | Level interrupt |

## Verification
Two pairs of functions can fall in the same cycle.

The first pair is a hardware set of a status bit and a software write-one-clear of that same bit. The bench drives both at once, then reads the status back and expects the bit to remain set.

The second pair is a counter increment and a clear-on-read of that counter. The bench drives both at once and expects the read to return the old count and a following read to return 1.

Random cycles mix sparse events, done pulses and random accesses. These cycles produce further collisions of both kinds. A cycle model built from the requirements judges `irq` and `reg_rdata` on every cycle.

// File: rtl/dma_irq_pkg.sv
package dma_irq_pkg;
  localparam int BIT_BAD_ACC  = 0;
  localparam int BIT_SRC_DONE = 1;
  localparam int BIT_DST_DONE = 2;
  localparam int BIT_SRC_ACCT = 4;
  localparam int BIT_DST_ACCT = 5;

  localparam int OFS_STAT = 0;
  localparam int OFS_MASK = 1;
  localparam int OFS_UNMASK = 2;
  localparam int OFS_MASKSET = 3;
  localparam int OFS_SRC_CNT = 4;
  localparam int OFS_DST_CNT = 5;

  typedef struct packed {
    logic stat;
    logic mask;
    logic unmask;
    logic maskset;
    logic src_cnt;
    logic dst_cnt;
    logic bad;
  } reg_hit_t;
endpackage

// File: rtl/dma_irq_decode.sv
module dma_irq_decode
  import dma_irq_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              req,
  input  logic [ADDR_W-1:0] addr,
  output reg_hit_t          hit
);
  always_comb begin
    hit = '0;
    if (req) begin
      if (addr == ADDR_W'(OFS_STAT))         hit.stat    = 1'b1;
      else if (addr == ADDR_W'(OFS_MASK))    hit.mask    = 1'b1;
      else if (addr == ADDR_W'(OFS_UNMASK))  hit.unmask  = 1'b1;
      else if (addr == ADDR_W'(OFS_MASKSET)) hit.maskset = 1'b1;
      else if (addr == ADDR_W'(OFS_SRC_CNT)) hit.src_cnt = 1'b1;
      else if (addr == ADDR_W'(OFS_DST_CNT)) hit.dst_cnt = 1'b1;
      else                                   hit.bad     = 1'b1;
    end
  end
endmodule

// File: rtl/dma_irq_acct.sv
module dma_irq_acct #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  input  logic             rd_clr,
  output logic [CNT_W-1:0] cnt,
  output logic             wrap
);
  assign wrap = inc && (cnt == '1);

  always_ff @(posedge clk) begin
    if (!rst_n)      cnt <= '0;
    else if (rd_clr) cnt <= CNT_W'(inc);
    else if (inc)    cnt <= cnt + CNT_W'(1);
  end
endmodule

// File: rtl/dma_irq_stat.sv
module dma_irq_stat #(
  parameter int NSRC = 12
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] set_vec,
  input  logic [NSRC-1:0] clr_vec,
  input  logic [NSRC-1:0] unmask_vec,
  input  logic [NSRC-1:0] maskset_vec,
  output logic [NSRC-1:0] status,
  output logic [NSRC-1:0] mask,
  output logic            irq
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      status <= '0;
      mask   <= '1;
      irq    <= 1'b0;
    end else begin
      status <= (status & ~clr_vec) | set_vec;
      mask   <= (mask & ~unmask_vec) | maskset_vec;
      irq    <= |(status & ~mask);
    end
  end
endmodule

// File: rtl/dma_irq_ctrl.sv
module dma_irq_ctrl
  import dma_irq_pkg::*;
#(
  parameter int NSRC   = 12,
  parameter int CNT_W  = 8,
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   evt_set,
  input  logic              src_dscr_done,
  input  logic              dst_dscr_done,
  input  logic              reg_req,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq
);
  localparam int NCNT = 2;

  reg_hit_t          hit;
  logic [NSRC-1:0]   status_q, mask_q, set_vec, clr_vec, unmask_vec, maskset_vec;
  logic [NSRC-1:0]   wdata_s;
  logic [NCNT-1:0]   cnt_inc, cnt_rd, cnt_wrap;
  logic [CNT_W-1:0]  cnt_val [NCNT];
  logic [CNT_W-1:0]  src_cnt;
  logic              rd_en, wr_en;
  logic [DATA_W-1:0] rd_val;

  dma_irq_decode #(.ADDR_W(ADDR_W)) u_dec (
    .req(reg_req), .addr(reg_addr), .hit(hit)
  );

  assign rd_en   = reg_req && !reg_we;
  assign wr_en   = reg_req && reg_we;
  assign wdata_s = reg_wdata[NSRC-1:0];
  assign cnt_inc = {dst_dscr_done, src_dscr_done};
  assign cnt_rd  = {hit.dst_cnt && rd_en, hit.src_cnt && rd_en};

  for (genvar g = 0; g < NCNT; g++) begin : g_acct
    dma_irq_acct #(.CNT_W(CNT_W)) u_acct (
      .clk(clk), .rst_n(rst_n), .inc(cnt_inc[g]), .rd_clr(cnt_rd[g]),
      .cnt(cnt_val[g]), .wrap(cnt_wrap[g])
    );
  end
  assign src_cnt = cnt_val[0];

  always_comb begin
    set_vec = evt_set;
    set_vec[BIT_SRC_DONE] = evt_set[BIT_SRC_DONE] | src_dscr_done;
    set_vec[BIT_DST_DONE] = evt_set[BIT_DST_DONE] | dst_dscr_done;
    set_vec[BIT_SRC_ACCT] = evt_set[BIT_SRC_ACCT] | cnt_wrap[0];
    set_vec[BIT_DST_ACCT] = evt_set[BIT_DST_ACCT] | cnt_wrap[1];
    set_vec[BIT_BAD_ACC]  = evt_set[BIT_BAD_ACC]  | hit.bad;
  end

  assign clr_vec     = (wr_en && hit.stat)    ? wdata_s : '0;
  assign unmask_vec  = (wr_en && hit.unmask)  ? wdata_s : '0;
  assign maskset_vec = (wr_en && hit.maskset) ? wdata_s : '0;

  dma_irq_stat #(.NSRC(NSRC)) u_stat (
    .clk(clk), .rst_n(rst_n), .set_vec(set_vec), .clr_vec(clr_vec),
    .unmask_vec(unmask_vec), .maskset_vec(maskset_vec),
    .status(status_q), .mask(mask_q), .irq(irq)
  );

  always_comb begin
    rd_val = '0;
    if (hit.stat)         rd_val = DATA_W'(status_q);
    else if (hit.mask)    rd_val = DATA_W'(mask_q);
    else if (hit.src_cnt) rd_val = DATA_W'(cnt_val[0]);
    else if (hit.dst_cnt) rd_val = DATA_W'(cnt_val[1]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     reg_rdata <= '0;
    else if (rd_en) reg_rdata <= rd_val;
  end
endmodule

// File: rtl/dma_irq_ctrl_chk.sv
module dma_irq_ctrl_chk #(
  parameter int NSRC   = 12,
  parameter int CNT_W  = 8,
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NSRC-1:0]   evt_set,
  input logic              src_dscr_done,
  input logic              dst_dscr_done,
  input logic              reg_req,
  input logic              reg_we,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [DATA_W-1:0] reg_wdata,
  input logic [NSRC-1:0]   status,
  input logic [NSRC-1:0]   mask,
  input logic [CNT_W-1:0]  src_cnt
);
  // R3
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt_set) |=> ((status & $past(evt_set)) == $past(evt_set)));

  // R10
  unmapped_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_req && reg_addr > ADDR_W'(5)) |=> status[0]);

  // R8
  acct_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (src_dscr_done && src_cnt == '1) |=> status[4]);

  // R5
  mask_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_req && reg_we && reg_addr == ADDR_W'(2))
      |=> ((mask & $past(reg_wdata[NSRC-1:0])) == '0));

  // R5
  mask_disable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_req && reg_we && reg_addr == ADDR_W'(3))
      |=> ((mask & $past(reg_wdata[NSRC-1:0])) == $past(reg_wdata[NSRC-1:0])));

  // R2
  status_w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_req && reg_we && reg_addr == ADDR_W'(0) && evt_set == '0
     && !src_dscr_done && !dst_dscr_done)
      |=> ((status & $past(reg_wdata[NSRC-1:0])) == '0));
endmodule

bind dma_irq_ctrl dma_irq_ctrl_chk #(
  .NSRC(NSRC), .CNT_W(CNT_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .evt_set(evt_set),
  .src_dscr_done(src_dscr_done), .dst_dscr_done(dst_dscr_done),
  .reg_req(reg_req), .reg_we(reg_we), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .status(status_q), .mask(mask_q), .src_cnt(src_cnt)
);

// File: tb/dma_irq_ctrl_bench.sv
module dma_irq_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] evt_set = '0;
  logic        src_dscr_done = 1'b0, dst_dscr_done = 1'b0;
  logic        reg_req = 1'b0, reg_we = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq;

  int n_chk = 0, n_fail = 0;
  bit done_flag = 0;

  logic [11:0] m_stat = '0, m_mask = 12'hFFF;
  logic [7:0]  m_src = '0, m_dst = '0;
  logic        m_irq = 1'b0;
  logic [31:0] m_rdata = '0;

  always #2.5 clk = ~clk;

  dma_irq_ctrl u_dma_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .evt_set(evt_set),
    .src_dscr_done(src_dscr_done), .dst_dscr_done(dst_dscr_done),
    .reg_req(reg_req), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic string rd_tag(input logic [3:0] a);
    case (a)
      4'd0: return "R2";
      4'd1: return "R4";
      4'd2, 4'd3: return "R5";
      4'd4, 4'd5: return "R9";
      default: return "R10";
    endcase
  endfunction

  function automatic logic [31:0] model_read(input logic [3:0] a);
    case (a)
      4'd0: return {20'h0, m_stat};
      4'd1: return {20'h0, m_mask};
      4'd4: return {24'h0, m_src};
      4'd5: return {24'h0, m_dst};
      default: return 32'h0;
    endcase
  endfunction

  task automatic step(input logic [11:0] evt, input logic sd, input logic dd,
                      input logic req, input logic we, input logic [3:0] addr,
                      input logic [31:0] wd, input string tag = "");
    logic rd, bad;
    logic [11:0] set, clr;
    @(negedge clk);
    evt_set = evt; src_dscr_done = sd; dst_dscr_done = dd;
    reg_req = req; reg_we = we; reg_addr = addr; reg_wdata = wd;
    @(posedge clk);
    rd  = req && !we;
    bad = req && addr > 4'd5;
    set = evt;
    if (sd) set[1] = 1'b1;
    if (dd) set[2] = 1'b1;
    if (sd && m_src == 8'hFF) set[4] = 1'b1;
    if (dd && m_dst == 8'hFF) set[5] = 1'b1;
    if (bad) set[0] = 1'b1;
    clr = (req && we && addr == 4'd0) ? wd[11:0] : 12'h0;
    m_irq = |(m_stat & ~m_mask);
    if (rd) m_rdata = model_read(addr);
    m_stat = (m_stat & ~clr) | set;
    if (req && we && addr == 4'd2) m_mask = m_mask & ~wd[11:0];
    if (req && we && addr == 4'd3) m_mask = m_mask | wd[11:0];
    if (rd && addr == 4'd4) m_src = {7'h0, sd}; else m_src = m_src + {7'h0, sd};
    if (rd && addr == 4'd5) m_dst = {7'h0, dd}; else m_dst = m_dst + {7'h0, dd};
    #1;
    chk("R6 irq", {31'h0, irq}, {31'h0, m_irq});
    if (rd) chk(tag != "" ? tag : rd_tag(addr), reg_rdata, m_rdata);
    else    chk("R11 hold", reg_rdata, m_rdata);
  endtask

  task automatic idle(); step('0, 0, 0, 0, 0, '0, '0); endtask
  task automatic rd(input logic [3:0] a, input string tag); step('0, 0, 0, 1, 0, a, '0, tag); endtask
  task automatic wr(input logic [3:0] a, input logic [31:0] d); step('0, 0, 0, 1, 1, a, d); endtask

  initial begin
    #(5 * 150000);
    n_fail++; n_chk++;
    $display("FAIL watchdog: actual hung expected finish");
    if (!done_flag) begin
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (4) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #1; chk("R6 reset irq", {31'h0, irq}, 32'h0);
    rd(0, "R2 reset status");
    rd(1, "R4 reset mask");
    wr(1, 32'h0);
    rd(1, "R4 mask write ignored");
    // R1: each event bit lands at its own position
    for (int i = 0; i < 12; i++) begin
      step(12'(1 << i), 0, 0, 0, 0, '0, '0);
      rd(0, "R1 bit position");
      wr(0, 32'hFFF);
    end
    // R5 / R6: unmask bit 10 and see irq
    step(12'h400, 0, 0, 0, 0, '0, '0);
    wr(2, 32'h400);
    idle(); idle();
    rd(2, "R5 enable reads zero");
    rd(1, "R5 mask after enable");
    // R2: clear it
    wr(0, 32'h400);
    rd(0, "R2 w1c");
    idle();
    // R3: collision
    step(12'h008, 0, 0, 1, 1, 4'd0, 32'h008);
    rd(0, "R3 set wins");
    // R7
    step('0, 0, 1, 0, 0, '0, '0);
    rd(0, "R7 dst done bit");
    rd(5, "R7 dst count");
    // R8: 256 source increments
    for (int i = 0; i < 256; i++) step('0, 1, 0, 0, 0, '0, '0);
    rd(0, "R8 wrap error bit");
    rd(4, "R8 count wrapped");
    // R9
    repeat (3) step('0, 1, 0, 0, 0, '0, '0);
    rd(4, "R9 read count");
    rd(4, "R9 cleared");
    step('0, 1, 0, 0, 0, '0, '0);
    step('0, 1, 0, 1, 0, 4'd4, '0, "R9 read with inc");
    rd(4, "R9 inc survives");
    // R10
    wr(4'd9, 32'hFFFF_FFFF);
    rd(1, "R10 write ignored mask");
    rd(4'd12, "R10 reads zero");
    rd(0, "R10 flag set");
    // R5 disable
    wr(3, 32'h0F0);
    rd(1, "R5 mask after disable");
    rd(3, "R5 disable reads zero");
    // random mix
    for (int i = 0; i < 4000; i++) begin
      logic [11:0] e;
      logic [3:0] a;
      e = 12'($urandom & $urandom & $urandom & $urandom);
      a = 4'($urandom_range(0, 7));
      step(e, 1'($urandom_range(0, 3) == 0), 1'($urandom_range(0, 3) == 0),
           1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), a, $urandom);
    end
    done_flag = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule